// File: doc/BRIEF.md
# SDRAM Bank Recovery Tracker with Burst Interruption

This block follows the state of every bank of an SDRAM device as commands are issued to it. It watches a stream of commands: activate, read, write and no-operation. Each read or write carries a flag that asks for an automatic precharge and names a bank and a starting column. From that stream it reports, per bank, whether the bank is idle, open, recovering from a write, or precharging. It also produces strobes that mark which cycles carry write data into the device and which cycles carry read data out of it.

The case the block is built around is a write burst with automatic precharge that is cut short. This happens when a legal read or write to another bank arrives while the burst is still running. The interrupted bank stops taking data at once. Its write-recovery time is counted from the cycle of the interrupting command, not from the end of the full burst. After write recovery it precharges for a fixed time and then becomes idle again.

A command that does not fit the target bank's state is refused. A one-cycle flag reports the refusal, and the command changes nothing.

Top module: `sdram_ap_tracker`

## Requirements
- R1: After reset, every bank reads idle (state code 00), and `wr_accept_o`, `rd_valid_o` and `illegal_o` are low.
- R2: An activate command (`cmd_i` = 01) to an idle bank makes that bank read open (code 01) from the next cycle on.
- R3: A legal write (`cmd_i` = 11) starts a burst of four beats. `wr_accept_o` is high in the command's own cycle and in the three cycles after it, and `wr_bank_o` names the bank. The beat columns keep the upper column bits of the start column. The low two bits count up by one per beat, modulo 4, from the start column.
- R4: A legal read or write arriving while a write burst runs ends that burst. The old bank's last beat is the cycle before the new command. If the new command is a write, its first beat is taken in that same cycle.
- R5: When a write burst with automatic precharge runs to its end, the bank reads write-recovery (code 10) from the cycle after its last beat for TWR cycles. It then reads precharging (code 11) for TRP cycles, and after that it reads idle.
- R6: When such a burst is interrupted at cycle I, the bank reads write-recovery from I+1. It reads precharging from I+TWR and idle from I+TWR+TRP.
- R7: A legal read (`cmd_i` = 10) at cycle I raises `rd_valid_o` in cycles I+CL through I+CL+3, and `rd_bank_o` names the bank during those cycles.
- R8: A legal read with automatic precharge moves its bank to precharging for the TRP cycles after the command, and the bank reads idle after that.
- R9: A command is illegal in three cases: an activate to a bank that is not idle, a read or write to a bank that is not open, or a read or write to a bank whose own auto-precharge write burst is running. An illegal command raises `illegal_o` in the next cycle only. It changes no bank state, accepts no write beat, produces no read strobe and does not cut a running burst.
- R10: A read or write without automatic precharge leaves its bank open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command: 00 none, 01 activate, 10 read, 11 write |
| cmd_ap_i | input | 1 | Automatic precharge request for read or write |
| cmd_bank_i | input | BANK_W | Target bank |
| cmd_col_i | input | COL_W | Start column |
| bank_state_o | output | 2*NUM_BANKS | Two bits per bank; bank b at bits 2b+1:2b |
| illegal_o | output | 1 | Previous cycle's command was refused |
| wr_accept_o | output | 1 | A write data beat is taken this cycle |
| wr_bank_o | output | BANK_W | Bank of the current write beat |
| wr_col_o | output | COL_W | Column of the current write beat |
| rd_valid_o | output | 1 | A read data beat is due this cycle |
| rd_bank_o | output | BANK_W | Bank of the current read beat |

## Verification
The write strobe, its bank and its column depend on the command in the same cycle. The bench reads them a short delay after it drives the command, before the clock edge. Bank states and the refusal flag change one edge after the command that causes them, and the read strobe appears CL edges after its read. The bench therefore numbers every cycle after reset and computes, from these offsets and TWR, TRP and CL, the value each output must hold in that cycle. It sweeps the interrupt offset across every beat of a burst and past its end, for both kinds of interrupting command, with and without automatic precharge.

// File: rtl/sdram_trk_pkg.sv
`timescale 1ns/1ps
package sdram_trk_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_ACTIVE = 2'd1,
        BK_WREC   = 2'd2,
        BK_PRECH  = 2'd3
    } bank_st_e;

    localparam int BURST_LEN = 4;

    // low column bits of beat n inside an aligned group of four
    function automatic logic [1:0] beat_lsb(input logic [1:0] base, input logic [1:0] beat);
        return base + beat;
    endfunction

endpackage

// File: rtl/sdram_bank_fsm.sv
`timescale 1ns/1ps
module sdram_bank_fsm
    import sdram_trk_pkg::*;
#(
    parameter int TWR = 2,
    parameter int TRP = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     act_i,
    input  logic     rdap_i,
    input  logic     rec_full_i,
    input  logic     rec_cut_i,
    output bank_st_e state_o
);
    localparam int MAXT  = (TWR > TRP) ? TWR : TRP;
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] TWR_C  = CNT_W'(TWR);
    localparam logic [CNT_W-1:0] TWR_C1 = CNT_W'(TWR - 1);
    localparam logic [CNT_W-1:0] TRP_C  = CNT_W'(TRP);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    bank_st_e       st_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                BK_IDLE: if (act_i) st_q <= BK_ACTIVE;
                BK_ACTIVE: begin
                    if (rdap_i) begin
                        st_q  <= BK_PRECH;
                        cnt_q <= TRP_C;
                    end else if (rec_full_i) begin
                        st_q  <= BK_WREC;
                        cnt_q <= TWR_C;
                    end else if (rec_cut_i) begin
                        // interrupt cycle already counts as the first recovery cycle
                        if (TWR > 1) begin
                            st_q  <= BK_WREC;
                            cnt_q <= TWR_C1;
                        end else begin
                            st_q  <= BK_PRECH;
                            cnt_q <= TRP_C;
                        end
                    end
                end
                BK_WREC: begin
                    if (cnt_q == ONE_C) begin
                        st_q  <= BK_PRECH;
                        cnt_q <= TRP_C;
                    end else begin
                        cnt_q <= cnt_q - ONE_C;
                    end
                end
                default: begin
                    if (cnt_q == ONE_C) st_q <= BK_IDLE;
                    else cnt_q <= cnt_q - ONE_C;
                end
            endcase
        end
    end

    assign state_o = st_q;

    a_r2_idle_exit: assert property (@(posedge clk) disable iff (rst)
        st_q == BK_IDLE |=> st_q inside {BK_IDLE, BK_ACTIVE});
    a_r5_rec_exit: assert property (@(posedge clk) disable iff (rst)
        st_q == BK_WREC |=> st_q inside {BK_WREC, BK_PRECH});
    a_r5_prech_exit: assert property (@(posedge clk) disable iff (rst)
        st_q == BK_PRECH |=> st_q inside {BK_PRECH, BK_IDLE});
    a_r6_cut_leaves_open: assert property (@(posedge clk) disable iff (rst)
        (rec_cut_i && st_q == BK_ACTIVE && !rdap_i) |=> st_q inside {BK_WREC, BK_PRECH});

endmodule

// File: rtl/sdram_wr_burst.sv
`timescale 1ns/1ps
module sdram_wr_burst
    import sdram_trk_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cut_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              ap_i,
    input  logic [COL_W-1:0]  col_i,
    output logic              acc_o,
    output logic [BANK_W-1:0] acc_bank_o,
    output logic [COL_W-1:0]  acc_col_o,
    output logic              ap_busy_o,
    output logic [BANK_W-1:0] busy_bank_o,
    output logic              rec_full_o,
    output logic              rec_cut_o
);
    localparam logic [1:0] LAST_BEAT = 2'(BURST_LEN - 1);

    logic              act_q, ap_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic [1:0]        beat_q;
    logic              cont;

    assign cont        = act_q && !cut_i;
    assign acc_o       = start_i || cont;
    assign acc_bank_o  = start_i ? bank_i : bank_q;
    assign acc_col_o   = start_i ? col_i : {col_q[COL_W-1:2], beat_lsb(col_q[1:0], beat_q)};
    assign ap_busy_o   = act_q && ap_q;
    assign busy_bank_o = bank_q;
    assign rec_full_o  = cont && ap_q && (beat_q == LAST_BEAT);
    assign rec_cut_o   = act_q && ap_q && cut_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            ap_q   <= 1'b0;
            bank_q <= '0;
            col_q  <= '0;
            beat_q <= '0;
        end else if (start_i) begin
            act_q  <= 1'b1;
            ap_q   <= ap_i;
            bank_q <= bank_i;
            col_q  <= col_i;
            beat_q <= 2'd1;
        end else if (cut_i) begin
            act_q <= 1'b0;
        end else if (act_q) begin
            if (beat_q == LAST_BEAT) act_q <= 1'b0;
            beat_q <= beat_q + 2'd1;
        end
    end

    a_r3_beats_contiguous: assert property (@(posedge clk) disable iff (rst)
        (acc_o && !start_i) |-> $past(acc_o));
    a_r4_cut_ends: assert property (@(posedge clk) disable iff (rst)
        (act_q && cut_i && !start_i) |=> (!acc_o || start_i));

endmodule

// File: rtl/sdram_rd_pipe.sv
`timescale 1ns/1ps
module sdram_rd_pipe
    import sdram_trk_pkg::*;
#(
    parameter int CL     = 3,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic              valid_o,
    output logic [BANK_W-1:0] bank_o
);
    logic [CL-1:0]     v_q;
    logic [BANK_W-1:0] b_q [CL];
    logic [1:0]        left_q;
    logic [BANK_W-1:0] lb_q;
    logic              head;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q[0] <= 1'b0;
            b_q[0] <= '0;
        end else begin
            v_q[0] <= go_i;
            b_q[0] <= bank_i;
        end
    end

    for (genvar g = 1; g < CL; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q[g] <= 1'b0;
                b_q[g] <= '0;
            end else begin
                v_q[g] <= v_q[g-1];
                b_q[g] <= b_q[g-1];
            end
        end
    end

    assign head = v_q[CL-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            lb_q   <= '0;
        end else if (head) begin
            left_q <= 2'(BURST_LEN - 1);
            lb_q   <= b_q[CL-1];
        end else if (left_q != 2'd0) begin
            left_q <= left_q - 2'd1;
        end
    end

    assign valid_o = head || (left_q != 2'd0);
    assign bank_o  = head ? b_q[CL-1] : lb_q;

    a_r7_rd_contiguous: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !head) |-> $past(valid_o));

endmodule

// File: rtl/sdram_ap_tracker.sv
`timescale 1ns/1ps
module sdram_ap_tracker
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int COL_W     = 8,
    parameter int TWR       = 2,
    parameter int TRP       = 3,
    parameter int CL        = 3,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             cmd_i,
    input  logic                   cmd_ap_i,
    input  logic [BANK_W-1:0]      cmd_bank_i,
    input  logic [COL_W-1:0]       cmd_col_i,
    output logic [2*NUM_BANKS-1:0] bank_state_o,
    output logic                   illegal_o,
    output logic                   wr_accept_o,
    output logic [BANK_W-1:0]      wr_bank_o,
    output logic [COL_W-1:0]       wr_col_o,
    output logic                   rd_valid_o,
    output logic [BANK_W-1:0]      rd_bank_o
);
    cmd_e              cmd;
    bank_st_e          st [NUM_BANKS];
    bank_st_e          tgt_st;
    logic              legal, wr_start, rd_go, cut, lock;
    logic              ap_busy, rec_full, rec_cut;
    logic [BANK_W-1:0] busy_bank;
    logic              illegal_q;

    assign cmd    = cmd_e'(cmd_i);
    assign tgt_st = st[cmd_bank_i];
    assign lock   = ap_busy && (busy_bank == cmd_bank_i);

    always_comb begin
        case (cmd)
            CMD_ACT:        legal = (tgt_st == BK_IDLE);
            CMD_RD, CMD_WR: legal = (tgt_st == BK_ACTIVE) && !lock;
            default:        legal = 1'b1;
        endcase
    end

    assign wr_start = (cmd == CMD_WR) && legal;
    assign rd_go    = (cmd == CMD_RD) && legal;
    assign cut      = wr_start || rd_go;

    always_ff @(posedge clk) begin
        if (rst) illegal_q <= 1'b0;
        else     illegal_q <= !legal;
    end
    assign illegal_o = illegal_q;

    sdram_wr_burst #(.BANK_W(BANK_W), .COL_W(COL_W)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .start_i    (wr_start),
        .cut_i      (cut),
        .bank_i     (cmd_bank_i),
        .ap_i       (cmd_ap_i),
        .col_i      (cmd_col_i),
        .acc_o      (wr_accept_o),
        .acc_bank_o (wr_bank_o),
        .acc_col_o  (wr_col_o),
        .ap_busy_o  (ap_busy),
        .busy_bank_o(busy_bank),
        .rec_full_o (rec_full),
        .rec_cut_o  (rec_cut)
    );

    sdram_rd_pipe #(.CL(CL), .BANK_W(BANK_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .go_i   (rd_go),
        .bank_i (cmd_bank_i),
        .valid_o(rd_valid_o),
        .bank_o (rd_bank_o)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit, rec_hit;
        assign hit     = (cmd_bank_i == BANK_W'(b));
        assign rec_hit = (busy_bank == BANK_W'(b));

        sdram_bank_fsm #(.TWR(TWR), .TRP(TRP)) u_fsm (
            .clk       (clk),
            .rst       (rst),
            .act_i     ((cmd == CMD_ACT) && legal && hit),
            .rdap_i    (rd_go && cmd_ap_i && hit),
            .rec_full_i(rec_full && rec_hit),
            .rec_cut_i (rec_cut && rec_hit),
            .state_o   (st[b])
        );
        assign bank_state_o[2*b +: 2] = st[b];
    end

    a_r9_illegal_no_burst: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !$past(wr_start));
    a_r9_illegal_no_read: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !$past(rd_go));

endmodule

// File: tb/sdram_ap_tracker_tb.sv
`timescale 1ns/1ps
module sdram_ap_tracker_tb;
    localparam int NB = 4, CW = 8, TWR = 2, TRP = 3, CL = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic [1:0] cmd_i = 2'd0;
    logic cmd_ap_i = 1'b0;
    logic [1:0] cmd_bank_i = 2'd0;
    logic [CW-1:0] cmd_col_i = '0;
    logic [2*NB-1:0] bank_state_o;
    logic illegal_o, wr_accept_o, rd_valid_o;
    logic [1:0] wr_bank_o, rd_bank_o;
    logic [CW-1:0] wr_col_o;

    int errs = 0, checks = 0;
    bit done = 1'b0;

    // sampled copies
    logic s_acc, s_rdv, s_ill;
    logic [1:0] s_wb, s_rb;
    logic [CW-1:0] s_wc;
    logic [2*NB-1:0] s_st;

    sdram_ap_tracker #(.NUM_BANKS(NB), .COL_W(CW), .TWR(TWR), .TRP(TRP), .CL(CL)) u_dut (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .cmd_ap_i(cmd_ap_i), .cmd_bank_i(cmd_bank_i),
        .cmd_col_i(cmd_col_i), .bank_state_o(bank_state_o), .illegal_o(illegal_o),
        .wr_accept_o(wr_accept_o), .wr_bank_o(wr_bank_o), .wr_col_o(wr_col_o),
        .rd_valid_o(rd_valid_o), .rd_bank_o(rd_bank_o));

    always #10 clk = ~clk; // 50 MHz

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive one cycle's command and sample all outputs for that cycle
    task automatic tick(input int c, input bit ap, input int b, input int col);
        @(negedge clk);
        cmd_i = 2'(c); cmd_ap_i = ap; cmd_bank_i = 2'(b); cmd_col_i = CW'(col);
        #2;
        s_acc = wr_accept_o; s_wb = wr_bank_o; s_wc = wr_col_o;
        s_rdv = rd_valid_o; s_rb = rd_bank_o; s_ill = illegal_o; s_st = bank_state_o;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd_i = 2'd0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int bst(input int b);
        return int'(s_st[2*b +: 2]);
    endfunction

    // state of a bank after an auto-precharge write whose recovery starts at s
    function automatic int exp_ap(input int c, input int s, input bit cut);
        if (c < s) return 1;
        if (c == s) return cut ? 1 : 2;
        if (c < s + TWR) return 2;
        if (c < s + TWR + TRP) return 3;
        return 0;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        tick(0, 0, 0, 0);
        chk("R1", "bank states", int'(s_st), 0);
        chk("R1", "wr_accept", int'(s_acc), 0);
        chk("R1", "rd_valid", int'(s_rdv), 0);
        chk("R1", "illegal", int'(s_ill), 0);

        // sweep: interrupt offset k, interrupting kind, its auto-precharge flag
        for (int k = 1; k <= 4; k++) begin
            for (int isw = 0; isw < 2; isw++) begin
                for (int iap = 0; iap < 2; iap++) begin
                    int T, I, ic;
                    T = 2; I = T + k; ic = isw ? 3 : 2;
                    do_reset();
                    for (int c = 0; c <= T + 20; c++) begin
                        bit e1, e2, erd;
                        int eb2;
                        if (c == 0) tick(1, 0, 1, 0);
                        else if (c == 1) tick(1, 0, 2, 0);
                        else if (c == T) tick(3, 1, 1, 'h40);
                        else if (c == I) tick(ic, iap[0], 2, 'h80);
                        else tick(0, 0, 0, 0);
                        if (c == 2) chk("R2", "bank1 opened", bst(1), 1);
                        if (c < T) continue;
                        // R3 / R4 write beats
                        e1 = (c <= T + 3) && (c < I);
                        e2 = isw && (c >= I) && (c <= I + 3);
                        chk("R4", "wr_accept", int'(s_acc), int'(e1 | e2));
                        if (e1) begin
                            chk("R3", "wr_bank old", int'(s_wb), 1);
                            chk("R3", "wr_col old", int'(s_wc), 'h40 + (c - T));
                        end
                        if (e2) begin
                            chk("R4", "wr_bank new", int'(s_wb), 2);
                            chk("R4", "wr_col new", int'(s_wc), 'h80 + (c - I));
                        end
                        // R7 read strobe
                        erd = !isw && (c >= I + CL) && (c <= I + CL + 3);
                        chk("R7", "rd_valid", int'(s_rdv), int'(erd));
                        if (erd) chk("R7", "rd_bank", int'(s_rb), 2);
                        // R5 / R6 interrupted or natural recovery of bank 1
                        if (k < 4) chk("R6", "bank1 cut recovery", bst(1), exp_ap(c, I, 1'b1));
                        else       chk("R5", "bank1 full recovery", bst(1), exp_ap(c, T + 4, 1'b0));
                        // bank 2
                        if (isw && iap) eb2 = exp_ap(c, I + 4, 1'b0);
                        else if (!isw && iap) eb2 = (c <= I) ? 1 : (c <= I + TRP) ? 3 : 0;
                        else eb2 = 1;
                        if (iap) chk("R8", "bank2 state", bst(2), eb2);
                        else     chk("R10", "bank2 stays open", bst(2), eb2);
                        chk("R9", "no illegal in sweep", int'(s_ill), 0);
                    end
                end
            end
        end

        // directed refusals, wrap order, plain commands
        do_reset();
        for (int c = 0; c <= 26; c++) begin
            int eb0, ecol;
            bit eacc, erd, eill;
            case (c)
                0:  tick(2, 0, 0, 0);       // read to idle bank: refused
                1:  tick(1, 0, 0, 0);       // open bank 0
                2:  tick(1, 0, 0, 0);       // activate open bank: refused
                3:  tick(3, 1, 0, 'h1E);    // auto-precharge write, wrapping columns
                4:  tick(2, 0, 0, 0);       // read to own locked bank: refused
                8:  tick(3, 0, 0, 0);       // write during recovery: refused
                10: tick(1, 0, 0, 0);       // activate during precharge: refused
                12: tick(1, 0, 0, 0);       // reopen
                13: tick(3, 0, 0, 0);       // plain write
                18: tick(2, 0, 0, 0);       // plain read
                default: tick(0, 0, 0, 0);
            endcase
            eill = (c == 1) || (c == 3) || (c == 5) || (c == 9) || (c == 11);
            chk("R9", "illegal flag", int'(s_ill), int'(eill));
            eacc = (c >= 3 && c <= 6) || (c >= 13 && c <= 16);
            chk("R9", "wr_accept directed", int'(s_acc), int'(eacc));
            if (c >= 3 && c <= 6) begin
                ecol = 'h1C + ((2 + (c - 3)) % 4);
                chk("R3", "wrap column", int'(s_wc), ecol);
                chk("R3", "wrap bank", int'(s_wb), 0);
            end
            if (c >= 13 && c <= 16) chk("R10", "plain write column", int'(s_wc), c - 13);
            erd = (c >= 21 && c <= 24);
            chk("R9", "rd_valid directed", int'(s_rdv), int'(erd));
            if (c <= 1) eb0 = 0;
            else if (c <= 6) eb0 = 1;
            else if (c <= 8) eb0 = 2;
            else if (c <= 11) eb0 = 3;
            else if (c == 12) eb0 = 0;
            else eb0 = 1;
            if (c >= 13) chk("R10", "bank0 stays open", bst(0), eb0);
            else         chk("R9", "bank0 state", bst(0), eb0);
            chk("R9", "other banks idle", int'(s_st[2*NB-1:2]), 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule